// File: doc/BRIEF.md
# Integrity-Protected Wide Register File

This block is a bank of wide data registers. Each register is held as a set of 32-bit slices, and each slice is stored next to its own 7-bit detection code. The code is an odd-column-weight (39,32) code with minimum distance four. There is one synchronous write port and two combinational read ports. With the default width of eight slices, each register holds a 256-bit value in 312 stored bits. Setting the slice count to one gives a file of 32-bit general-purpose registers that store 39 bits each.

A write carries a mode bit. In pass-through mode the incoming word already holds valid codes, for example from a protected memory load, a register-to-register move or a conditional select. The block stores that word bit for bit without recomputing anything. In raw mode only the data fields are used: the block computes each slice's code and discards whatever the caller placed in the code fields.

Every enabled read checks every slice of the word it reads, even when the caller forwards the code along with the data. The port reports a per-slice mismatch mask. Any mismatch sets a sticky fatal flag, and while that flag is set the block accepts no further writes. The block never corrects data. It only detects errors and stops.

Top module: `wide_regfile_ecc`

## Requirements
- R1: Slice s of a stored word occupies bits [39s+38 : 39s]. Within a slice, bits [31:0] hold data and bits [38:32] hold the code.
- R2: Code column j (for data bit j, j = 0..31) is the j-th smallest 7-bit value with exactly three ones. Code bit i is the XOR of all data bits whose column has bit i set. This makes the all-zero slice a valid codeword.
- R3: A raw-mode write (`wr_mode_i` = 0) stores each slice's data together with the code computed under R2. The code fields of `wr_data_i` have no effect.
- R4: A pass-through write (`wr_mode_i` = 1) stores all bits of `wr_data_i` unchanged, including code fields that may be invalid.
- R5: Both read ports are combinational and independent. A write becomes visible on a read port from the cycle after its clock edge. In the write cycle itself, a read of the same address returns the old contents.
- R6: While a port's read enable is high, bit s of its error mask is 1 exactly when slice s of the addressed word fails the R2 check. Every flip of one, two or three bits within a single slice is flagged. With the enable low, the mask is zero.
- R7: The read data output always carries the stored word as it is, with no correction, even when its check fails.
- R8: `fatal_o` rises on the clock edge after any enabled read with a nonzero mask, on either port. It then stays high until reset.
- R9: While `fatal_o` is high, no write changes any register.
- R10: Reset clears every register to all zeros (a valid codeword) and clears `fatal_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Write register index |
| wr_mode_i | input | 1 | 1 = store encoded word as-is, 0 = compute codes |
| wr_data_i | input | 312 | Write word in slice layout |
| rd_en_a_i | input | 1 | Port A check enable |
| rd_addr_a_i | input | 5 | Port A register index |
| rd_data_a_o | output | 312 | Port A stored word |
| rd_err_a_o | output | 8 | Port A per-slice mismatch mask |
| rd_en_b_i | input | 1 | Port B check enable |
| rd_addr_b_i | input | 5 | Port B register index |
| rd_data_b_o | output | 312 | Port B stored word |
| rd_err_b_o | output | 8 | Port B per-slice mismatch mask |
| fatal_o | output | 1 | Sticky fatal integrity error |

## Verification
The bench injects faults through the pass-through write path. It writes codewords with one, two or three bits flipped inside a single slice, then reads them back. A corrupted stored word appears in the same cycle as a mask bit on whichever port reads it, and as `fatal_o` one edge later. An encoder fault shows up as a wrong code field on the first read after a raw write. A write-block fault shows up as a register whose contents change after `fatal_o` has risen, which the bench reads back directly.

// File: rtl/wide_regfile_ecc.sv
module wide_regfile_ecc #(
  parameter int NREGS  = 32,
  parameter int SLICES = 8,
  localparam int AW = $clog2(NREGS),
  localparam int DW = 32,
  localparam int CW = 7,
  localparam int SW = DW + CW,
  localparam int WW = SLICES * SW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic              wr_mode_i,
  input  logic [WW-1:0]     wr_data_i,
  input  logic              rd_en_a_i,
  input  logic [AW-1:0]     rd_addr_a_i,
  output logic [WW-1:0]     rd_data_a_o,
  output logic [SLICES-1:0] rd_err_a_o,
  input  logic              rd_en_b_i,
  input  logic [AW-1:0]     rd_addr_b_i,
  output logic [WW-1:0]     rd_data_b_o,
  output logic [SLICES-1:0] rd_err_b_o,
  output logic              fatal_o
);

  function automatic logic [CW-1:0][DW-1:0] build_rows();
    logic [CW-1:0][DW-1:0] r;
    int n;
    r = '0;
    n = 0;
    for (int v = 1; v < (1 << CW); v++) begin
      if ($countones(v) == 3 && n < DW) begin
        for (int i = 0; i < CW; i++) r[i][n] = v[i];
        n++;
      end
    end
    return r;
  endfunction

  localparam logic [CW-1:0][DW-1:0] ROWS = build_rows();

  function automatic logic [CW-1:0] encode(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    for (int i = 0; i < CW; i++) c[i] = ^(d & ROWS[i]);
    return c;
  endfunction

  logic [WW-1:0] regs_q [NREGS];
  logic [WW-1:0] raw_word;
  logic [WW-1:0] wr_word;
  logic          fatal_q;

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    logic [DW-1:0] wd, ad, bd;
    logic [CW-1:0] ac, bc;
    assign wd = wr_data_i[s*SW +: DW];
    assign raw_word[s*SW +: SW] = {encode(wd), wd};
    assign ad = rd_data_a_o[s*SW +: DW];
    assign ac = rd_data_a_o[s*SW+DW +: CW];
    assign bd = rd_data_b_o[s*SW +: DW];
    assign bc = rd_data_b_o[s*SW+DW +: CW];
    assign rd_err_a_o[s] = rd_en_a_i && (encode(ad) != ac);
    assign rd_err_b_o[s] = rd_en_b_i && (encode(bd) != bc);
  end

  assign wr_word     = wr_mode_i ? wr_data_i : raw_word;
  assign rd_data_a_o = regs_q[rd_addr_a_i];
  assign rd_data_b_o = regs_q[rd_addr_b_i];
  assign fatal_o     = fatal_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
    end else if (wr_en_i && !fatal_q) begin
      regs_q[wr_addr_i] <= wr_word;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fatal_q <= 1'b0;
    else if ((|rd_err_a_o) || (|rd_err_b_o)) fatal_q <= 1'b1;
  end

endmodule

// File: rtl/wide_regfile_ecc_chk.sv
module wide_regfile_ecc_chk #(
  parameter int NREGS  = 32,
  parameter int SLICES = 8,
  localparam int AW = $clog2(NREGS),
  localparam int WW = SLICES * 39
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [AW-1:0]     wr_addr_i,
  input logic              wr_mode_i,
  input logic [WW-1:0]     wr_data_i,
  input logic              rd_en_a_i,
  input logic [AW-1:0]     rd_addr_a_i,
  input logic [WW-1:0]     rd_data_a_o,
  input logic [SLICES-1:0] rd_err_a_o,
  input logic              rd_en_b_i,
  input logic [AW-1:0]     rd_addr_b_i,
  input logic [WW-1:0]     rd_data_b_o,
  input logic [SLICES-1:0] rd_err_b_o,
  input logic              fatal_o
);

  AST_FATAL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |=> fatal_o); // R8

  AST_ERR_TO_FATAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_en_a_i && |rd_err_a_o) || (rd_en_b_i && |rd_err_b_o)) |=> fatal_o); // R8

  AST_PASSTHRU_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_i && wr_mode_i && !fatal_o) && rd_addr_a_i == $past(wr_addr_i))
      |-> rd_data_a_o == $past(wr_data_i)); // R4

  AST_RAW_READS_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_i && !wr_mode_i && !fatal_o) && rd_addr_b_i == $past(wr_addr_i))
      |-> rd_err_b_o == '0); // R3

  AST_FROZEN_AFTER_FATAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(fatal_o) && $stable(rd_addr_a_i)) |-> $stable(rd_data_a_o)); // R9

  AST_MASK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_a_i |-> rd_err_a_o == '0); // R6

endmodule

bind wide_regfile_ecc wide_regfile_ecc_chk #(.NREGS(NREGS), .SLICES(SLICES)) chk_i (.*);

// File: tb/wide_regfile_ecc_tb_top.sv
`timescale 1ns/1ps
module wide_regfile_ecc_tb_top;
  localparam int NREGS = 32;
  localparam int SL    = 8;
  localparam int WW    = SL * 39;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 1'b0, wr_mode_i = 1'b0, rd_en_a_i = 1'b0, rd_en_b_i = 1'b0;
  logic [4:0] wr_addr_i = '0, rd_addr_a_i = '0, rd_addr_b_i = '0;
  logic [WW-1:0] wr_data_i = '0;
  logic [WW-1:0] rd_data_a_o, rd_data_b_o;
  logic [SL-1:0] rd_err_a_o, rd_err_b_o;
  logic fatal_o;

  always #2.5 clk_i = ~clk_i;

  wide_regfile_ecc #(.NREGS(NREGS), .SLICES(SL)) dut_i (.*);

  typedef struct {
    logic [WW-1:0] ad; logic [SL-1:0] am;
    logic [WW-1:0] bd; logic [SL-1:0] bm;
    logic f; string tag;
  } item_t;

  item_t sb_q[$];
  logic [WW-1:0] model [NREGS];
  logic mfatal;
  int checks = 0, errors = 0;

  function automatic logic [6:0] tb_code(logic [31:0] d);
    logic [6:0] c = '0;
    int k = 0;
    for (int hi = 2; hi < 7; hi++)
      for (int mid = 1; mid < hi; mid++)
        for (int lo = 0; lo < mid; lo++) begin
          if (k < 32 && d[k]) c ^= 7'((1 << lo) | (1 << mid) | (1 << hi));
          k++;
        end
    return c;
  endfunction

  function automatic logic [WW-1:0] tb_raw(logic [WW-1:0] w);
    logic [WW-1:0] r;
    for (int s = 0; s < SL; s++) r[s*39 +: 39] = {tb_code(w[s*39 +: 32]), w[s*39 +: 32]};
    return r;
  endfunction

  function automatic logic [SL-1:0] tb_mask(logic [WW-1:0] w);
    logic [SL-1:0] m;
    for (int s = 0; s < SL; s++) m[s] = tb_code(w[s*39 +: 32]) != w[s*39+32 +: 7];
    return m;
  endfunction

  function automatic logic [WW-1:0] pattern(int seed);
    logic [WW-1:0] w;
    for (int s = 0; s < SL; s++)
      w[s*39 +: 39] = {7'(7'h55 ^ 7'(s + seed)), 32'hA5C3_0F1E ^ (32'h0101_0101 * 32'(s + 3 * seed))};
    return w;
  endfunction

  task automatic step(input bit we, input int wa, input bit wm, input logic [WW-1:0] wd,
                      input bit ea, input int ra, input bit eb, input int rb, input string tag);
    item_t it;
    @(posedge clk_i); #1;
    wr_en_i = we; wr_addr_i = 5'(wa); wr_mode_i = wm; wr_data_i = wd;
    rd_en_a_i = ea; rd_addr_a_i = 5'(ra); rd_en_b_i = eb; rd_addr_b_i = 5'(rb);
    it.ad = model[ra]; it.am = ea ? tb_mask(model[ra]) : '0;
    it.bd = model[rb]; it.bm = eb ? tb_mask(model[rb]) : '0;
    it.f = mfatal; it.tag = tag;
    sb_q.push_back(it);
    if (we && !mfatal) model[wa] = wm ? wd : tb_raw(wd);
    if (it.am != 0 || it.bm != 0) mfatal = 1'b1;
  endtask

  task automatic do_reset();
    @(posedge clk_i); #1;
    rst_ni = 1'b0; wr_en_i = 0; rd_en_a_i = 0; rd_en_b_i = 0;
    for (int i = 0; i < NREGS; i++) model[i] = '0;
    mfatal = 1'b0;
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1'b1;
  endtask

  task automatic cmp(input string tag, input string what, input logic [WW-1:0] got, input logic [WW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      cmp(it.tag, "rd_data_a", rd_data_a_o, it.ad);
      cmp(it.tag, "rd_err_a", WW'(rd_err_a_o), WW'(it.am));
      cmp(it.tag, "rd_data_b", rd_data_b_o, it.bd);
      cmp(it.tag, "rd_err_b", WW'(rd_err_b_o), WW'(it.bm));
      cmp(it.tag, "fatal", WW'(fatal_o), WW'(it.f));
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [WW-1:0] good, bad;
    int p;
    do_reset();
    step(0, 0, 0, '0, 1, 0, 1, NREGS-1, "R10 reset");
    // R3 / R2 raw writes with garbage code fields, read on both ports
    step(1, 3, 0, pattern(1), 0, 0, 0, 0, "R3 write");
    step(1, 7, 0, pattern(2), 1, 3, 0, 0, "R3 read");
    step(0, 0, 0, '0, 1, 3, 1, 7, "R5 two ports R2");
    // R5 same-cycle write/read returns old
    step(1, 3, 0, pattern(5), 1, 3, 1, 3, "R5 old value");
    step(0, 0, 0, '0, 1, 3, 0, 0, "R5 new value");
    // R4 pass-through of valid codeword and of all-ones data
    step(1, 9, 1, tb_raw(pattern(7)), 0, 0, 0, 0, "R4 write");
    step(1, 10, 1, tb_raw('1), 1, 9, 1, 9, "R4 read");
    step(0, 0, 0, '0, 1, 10, 0, 9, "R4 read ones R1");
    // R6 disabled port on corrupted word: no mask, no fatal
    bad = tb_raw(pattern(3)); bad[5] = ~bad[5];
    step(1, 12, 1, bad, 0, 0, 0, 0, "R6 inject");
    step(0, 0, 0, '0, 0, 12, 0, 12, "R6 enable low");
    step(0, 0, 0, '0, 0, 12, 0, 12, "R6 no fatal");
    // R6/R7/R8/R9 injections: 1, 2, 3 flips in each slice
    for (int nf = 1; nf <= 3; nf++) begin
      for (int s = 0; s < SL; s++) begin
        do_reset();
        good = tb_raw(pattern(s + nf));
        bad = good;
        p = (s * 5 + nf) % 39;
        bad[s*39 + p] = ~bad[s*39 + p];
        if (nf >= 2) bad[s*39 + (p + 13) % 39] = ~bad[s*39 + (p + 13) % 39];
        if (nf >= 3) bad[s*39 + (p + 27) % 39] = ~bad[s*39 + (p + 27) % 39];
        step(1, 4, 1, bad, 0, 0, 0, 0, "R6 inject");
        step(1, 6, 0, pattern(9), (s % 2) == 0, 4, (s % 2) == 1, 4, "R6 R7 detect");
        step(1, 6, 1, good, 0, 0, 0, 0, "R8 fatal");
        step(0, 0, 0, '0, 0, 4, 0, 6, "R9 blocked");
        step(0, 0, 0, '0, 0, 6, 0, 6, "R8 sticky");
      end
    end
    do_reset();
    step(0, 0, 0, '0, 1, 4, 1, 6, "R10 clears fatal");
    repeat (3) @(posedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule